// File: doc/BRIEF.md
# Indirect Index/Data Register Window

This block maps a large target register space through a narrow I/O port. The port holds two words. The first is the index, which names a location in the target space. The second is the data word: an access to it is carried out at the target location the index names.

A write to the index keeps only the bits that name a whole word inside the 4 KiB target space. Bits above the window and the two byte-select bits are cleared. This means a forwarded access is always word aligned and always stays inside the target space. Any other address on the I/O port reads as zero and ignores writes.

Both sides use a request/acknowledge handshake. The I/O side raises `s_req` and holds it until `s_ack` pulses for one cycle. It must drop `s_req` before the clock edge that follows that pulse. An access to the data word is passed on to the target port as one word transfer. The I/O side waits until the target acknowledges that transfer.

Top module: `indirect_window`

## Requirements
- R1: After reset the stored index is zero, and both `s_ack` and `m_req` are low.
- R2: A write to the index word (byte address `WIN_OFFSET`) stores the written value ANDed with `(TGT_SIZE-1) & ~3`. A read of the index word returns the stored index, zero-extended, for example 0xFFFFFFFF reads back as 0xFFC.
- R3: A read of the data word (byte address `WIN_OFFSET+4`) issues one target read at the stored index with `m_we` low. It returns the `m_rdata` sampled with `m_ack` on `s_rdata`.
- R4: A write of the data word issues one target write at the stored index, with `m_we` high and `m_wdata` equal to the written value.
- R5: An access at any other I/O address reads zero, leaves the index unchanged and issues no target transfer.
- R6: During a forwarded access `m_req`, `m_addr`, `m_we` and `m_wdata` stay stable until `m_ack`. `s_ack` stays low while `m_req` is high. `s_ack` pulses on the cycle after `m_ack` is sampled, so a target that answers L cycles after seeing the request gives an I/O latency of 2+L cycles.
- R7: An index or other-address access is acknowledged with a one-cycle `s_ack` pulse on the cycle after the request is accepted.
- R8: Each forwarded access produces exactly one target transfer. `m_req` falls on the cycle after `m_ack`.
- R9: Data-word accesses do not modify the index. Consecutive data accesses reach the same target location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | I/O side request, held until acknowledged |
| s_we | input | 1 | I/O side write (1) or read (0) |
| s_addr | input | SLV_AW | I/O side byte address |
| s_wdata | input | DATA_W | I/O side write data |
| s_ack | output | 1 | One-cycle completion pulse to the I/O side |
| s_rdata | output | DATA_W | Read data, valid while s_ack is high |
| m_req | output | 1 | Target transfer request |
| m_we | output | 1 | Target transfer is a write |
| m_addr | output | TGT_AW | Target byte address (the stored index) |
| m_wdata | output | DATA_W | Target write data |
| m_rdata | input | DATA_W | Target read data, valid with m_ack |
| m_ack | input | 1 | Target completion pulse |

## Verification
Index writes use all-ones, patterns with stray byte-select bits, and patterns with bits above the window. Each of these shows whether the mask removes exactly the right bits. Data reads and writes run against target latencies from zero to five cycles, and the measured I/O latency is compared against 2+L. This separates a correct wait state from an acknowledgement that comes early or one cycle late. Writes to neighbouring, unaligned and distant addresses are followed by a read-back of the index and a count of target transfers, which shows that those writes had no effect. A sweep over several indices writes and then reads back distinct values, which exposes any drift of the index between accesses.

// File: rtl/ixw_pkg.sv
package ixw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RESP = 2'd2
    } ixw_state_e;
endpackage

// File: rtl/ixw_decode.sv
module ixw_decode #(
    parameter int SLV_AW     = 8,
    parameter int WIN_OFFSET = 32'h20
) (
    input  logic [SLV_AW-1:0] s_addr,
    output logic              hit_idx,
    output logic              hit_dat
);
    localparam logic [SLV_AW-1:0] IDX_ADDR = SLV_AW'(WIN_OFFSET);
    localparam logic [SLV_AW-1:0] DAT_ADDR = SLV_AW'(WIN_OFFSET + 4);

    always_comb begin
        hit_idx = (s_addr == IDX_ADDR);
        hit_dat = (s_addr == DAT_ADDR);
    end
endmodule

// File: rtl/ixw_index.sv
module ixw_index #(
    parameter int TGT_AW   = 12,
    parameter int TGT_SIZE = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TGT_AW-1:0] wr_val,
    output logic [TGT_AW-1:0] idx
);
    localparam logic [TGT_AW-1:0] KEEP_MASK = TGT_AW'((TGT_SIZE - 1) & ~3);

    logic [TGT_AW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (wr_en) begin
            idx_d = wr_val & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/ixw_fsm.sv
module ixw_fsm
    import ixw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TGT_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_we,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              hit_idx,
    input  logic              hit_dat,
    input  logic [TGT_AW-1:0] idx,
    output logic              idx_wr,
    output logic              s_ack,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [TGT_AW-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ack
);
    typedef struct packed {
        ixw_state_e        st;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        idx_wr = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (s_req) begin
                    if (hit_dat) begin
                        r_d.st    = ST_FWD;
                        r_d.we    = s_we;
                        r_d.wdata = s_wdata;
                    end else begin
                        r_d.st    = ST_RESP;
                        idx_wr    = s_we && hit_idx;
                        r_d.rdata = (!s_we && hit_idx) ? DATA_W'(idx) : '0;
                    end
                end
            end
            ST_FWD: begin
                if (m_ack) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = r_q.we ? '0 : m_rdata;
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, we: 1'b0, wdata: '0, rdata: '0};
        else        r_q <= r_d;
    end

    assign s_ack   = (r_q.st == ST_RESP);
    assign s_rdata = r_q.rdata;
    assign m_req   = (r_q.st == ST_FWD);
    assign m_we    = r_q.we;
    assign m_addr  = idx;
    assign m_wdata = r_q.wdata;

    // R6: forwarded transfer held stable until the target answers
    assert_fwd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    // R6: no completion to the I/O side while the target is busy
    assert_no_early_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> !s_ack);

    // R8: request withdrawn right after the target acknowledges
    assert_single_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> !m_req);

    // R7: completion is a single-cycle pulse
    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |=> !s_ack);

    // R5: a target transfer starts only from a data-word request
    assert_fwd_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_req) |-> $past(s_req && hit_dat));
endmodule

// File: rtl/indirect_window.sv
module indirect_window #(
    parameter int DATA_W     = 32,
    parameter int SLV_AW     = 8,
    parameter int WIN_OFFSET = 32'h20,
    parameter int TGT_SIZE   = 4096,
    localparam int TGT_AW    = $clog2(TGT_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_we,
    input  logic [SLV_AW-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_ack,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [TGT_AW-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ack
);
    logic              hit_idx, hit_dat, idx_wr;
    logic [TGT_AW-1:0] idx;

    ixw_decode #(.SLV_AW(SLV_AW), .WIN_OFFSET(WIN_OFFSET)) u_decode (
        .s_addr (s_addr),
        .hit_idx(hit_idx),
        .hit_dat(hit_dat)
    );

    ixw_index #(.TGT_AW(TGT_AW), .TGT_SIZE(TGT_SIZE)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (idx_wr),
        .wr_val(s_wdata[TGT_AW-1:0]),
        .idx   (idx)
    );

    ixw_fsm #(.DATA_W(DATA_W), .TGT_AW(TGT_AW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_req  (s_req),
        .s_we   (s_we),
        .s_wdata(s_wdata),
        .hit_idx(hit_idx),
        .hit_dat(hit_dat),
        .idx    (idx),
        .idx_wr (idx_wr),
        .s_ack  (s_ack),
        .s_rdata(s_rdata),
        .m_req  (m_req),
        .m_we   (m_we),
        .m_addr (m_addr),
        .m_wdata(m_wdata),
        .m_rdata(m_rdata),
        .m_ack  (m_ack)
    );
endmodule

// File: tb/test_indirect_window.sv
module test_indirect_window;
    localparam int DW  = 32;
    localparam int AW  = 8;
    localparam int OFS = 32'h20;
    localparam int TAW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_req = 1'b0, s_we = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic s_ack, m_req, m_we;
    logic [DW-1:0] s_rdata, m_wdata;
    logic [TAW-1:0] m_addr;
    logic [DW-1:0] m_rdata = '0;
    logic m_ack = 1'b0;

    int checks = 0, failures = 0, cycles = 0;
    int lat_cfg = 0, fwd_cnt = 0, resp_cnt = 0;
    int exp_idx = 0;
    logic cur_we = 1'b0;
    logic [DW-1:0] cur_wdata = '0;
    logic [DW-1:0] tgt_mem [int];
    logic [DW-1:0] ref_mem [int];
    bit done = 0;

    always #4 clk = ~clk;

    indirect_window i_indirect_window (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_ack(s_ack), .s_rdata(s_rdata), .m_req(m_req),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ack(m_ack)
    );

    function automatic logic [DW-1:0] fill_val(int a);
        return 32'hC0DE_0000 | DW'(a);
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Target register space: answers lat_cfg cycles after seeing the request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (m_ack) begin
                m_ack = 1'b0;
            end else if (m_req) begin
                if (cnt >= lat_cfg) begin
                    cnt = 0;
                    fwd_cnt++;
                    if (m_we) tgt_mem[int'(m_addr)] = m_wdata;
                    m_rdata = tgt_mem.exists(int'(m_addr)) ? tgt_mem[int'(m_addr)]
                                                           : fill_val(int'(m_addr));
                    m_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Per-clock comparison of the target-side transfer against the model
    always @(negedge clk) begin
        if (rst_n && m_req) begin
            check("R6 m_addr", DW'(m_addr), DW'(exp_idx));
            check("R4 m_we", DW'(m_we), DW'(cur_we));
            if (cur_we) check("R4 m_wdata", m_wdata, cur_wdata);
        end
        if (rst_n && m_req && s_ack) check("R6 overlap", 1, 0);
        cycles++;
    end

    task automatic access(input logic we, input int addr, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        cur_we = we; cur_wdata = wd;
        s_req = 1'b1; s_we = we; s_addr = AW'(addr); s_wdata = wd;
        lat = 0;
        rd = '0;
        while (lat < 100) begin
            @(negedge clk);
            lat++;
            if (s_ack) begin
                rd = s_rdata;
                break;
            end
        end
        s_req = 1'b0;
    endtask

    task automatic idx_write(int v);
        logic [DW-1:0] rd; int lat;
        access(1'b1, OFS, DW'(v), rd, lat);
        exp_idx = v & 32'hFFC;
        check("R7 index write latency", DW'(lat), 1);
    endtask

    task automatic idx_check(string req);
        logic [DW-1:0] rd; int lat;
        access(1'b0, OFS, '0, rd, lat);
        check(req, rd, DW'(exp_idx));
    endtask

    task automatic data_write(logic [DW-1:0] v, int l);
        logic [DW-1:0] rd; int lat; int c0;
        lat_cfg = l; c0 = fwd_cnt;
        access(1'b1, OFS + 4, v, rd, lat);
        ref_mem[exp_idx] = v;
        check("R6 write latency", DW'(lat), DW'(2 + l));
        check("R8 one write transfer", DW'(fwd_cnt - c0), 1);
    endtask

    task automatic data_read(int l);
        logic [DW-1:0] rd; int lat; int c0;
        lat_cfg = l; c0 = fwd_cnt;
        access(1'b0, OFS + 4, '0, rd, lat);
        check("R3 read data", rd, ref_mem.exists(exp_idx) ? ref_mem[exp_idx] : fill_val(exp_idx));
        check("R6 read latency", DW'(lat), DW'(2 + l));
        check("R8 one read transfer", DW'(fwd_cnt - c0), 1);
    endtask

    task automatic other_access(int a);
        logic [DW-1:0] rd; int lat; int c0;
        c0 = fwd_cnt;
        access(1'b1, a, 32'hFFFF_FFF0, rd, lat);
        check("R7 other write latency", DW'(lat), 1);
        access(1'b0, a, '0, rd, lat);
        check("R5 other read zero", rd, '0);
        check("R5 no transfer", DW'(fwd_cnt - c0), 0);
        idx_check("R5 index untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 s_ack reset", DW'(s_ack), 0);
        check("R1 m_req reset", DW'(m_req), 0);
        rst_n = 1'b1;
        idx_check("R1 index reset");

        idx_write(32'hFFFF_FFFF); idx_check("R2 all ones mask");
        idx_write(32'h0000_1237); idx_check("R2 high and low bits cleared");
        idx_write(32'h8000_0102); idx_check("R2 mixed pattern");

        idx_write(32'h100);
        data_read(0);
        data_write(32'hDEAD_BEEF, 2);
        data_read(1);
        idx_check("R9 index kept after data access");
        data_write(32'h1234_5678, 0);
        data_read(5);

        other_access(0);
        other_access(OFS + 8);
        other_access(OFS + 1);
        other_access(OFS - 4);

        for (int i = 0; i < 6; i++) begin
            idx_write(32'hF000_0000 | (i * 36 + 3));
            data_write(32'hA000_0000 + DW'(i), i % 4);
        end
        for (int i = 0; i < 6; i++) begin
            idx_write(i * 36);
            data_read((i + 1) % 5);
        end
        idx_write(32'hFFC); data_read(0);
        done = 1;
    end

    initial begin
        while (!done && cycles < 20000) @(negedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule